// File: doc/BRIEF.md
# Port Fault Recovery and Backoff Controller

This block decides when one powered port may be switched back on after a fault. Upstream logic reports a fault as a one-cycle pulse with a three-bit class code. The controller maps that code to a recovery profile. Retryable faults wait out a backoff that grows with each repeat and is capped in count. Hard faults latch the port off until the host clears it. Thermal faults hold the port off until a temperature reading falls below a limit. The output `restart_ok` is the permission that the power stage uses to re-enable the port.

Every fault pulse also produces one evidence record on a valid/ready output. The record holds a timestamp, the fault code, the port state in which the fault arrived, the retry count, the backoff stage and the recovery mode. Records never stall the controller. A record stays stable until it is accepted, unless a newer event overwrites it. Time is counted in pulses of `tick`, a 1 ms strobe.

Top module: `fault_recovery_ctrl`

## Requirements
- R1: Fault codes map to recovery modes, with mode codes retry=0, latch=1 and cool=2. Code 1 (short) maps to latch. Codes 2 (overcurrent), 3 (overpower), 5 (undervoltage) and 6 (detect anomaly) map to retry. Code 4 (overtemperature) maps to cool. The reserved codes 0 and 7 map to latch.
- R2: `restart_ok` is 1 after reset and whenever the port is in the running state. It reads 0 in the cycle after any `fault_valid` pulse.
- R3: A retry fault taken at retry count n (n below RETRY_MAX) sets the count to n+1 and uses backoff stage n. With exponential backoff the wait is min(BASE_TICKS·2^n, MAX_WAIT) ticks. With stepped backoff the wait is min(BASE_TICKS·(n+1), MAX_WAIT) ticks. `restart_ok` returns in the cycle after the last tick of the wait.
- R4: A retry fault that arrives when the count already equals RETRY_MAX escalates to latch-off. It is recorded with mode latch, and the count stays at RETRY_MAX.
- R5: In latch-off, ticks and further faults do not release the port. A `host_clear` pulse without a fault in the same cycle restores `restart_ok` in the next cycle and resets the retry count to 0.
- R6: In cool-down, `restart_ok` stays 0 while `temp` >= `cool_limit`, however many ticks pass. It rises in the cycle after `temp` < `cool_limit` is sampled. A retry fault during cool-down is recorded with mode cool and does not leave cool-down.
- R7: A retry fault during a backoff wait restarts the wait at the next stage, and its record shows port state 1 (wait).
- R8: The retry count returns to 0 after HOLD_TICKS consecutive ticks in the running state with no fault. HOLD_TICKS−1 such ticks leave it unchanged.
- R9: Each fault pulse loads one record and raises `ev_valid`. While `ev_valid` is 1 and `ev_ready` is 0, the record fields are held stable. A newer fault overwrites a pending record. `ev_valid` drops in the cycle after a handshake with no new event.
- R10: `host_clear` has no effect outside latch-off.
- R11: `ev_time` equals the number of `tick` pulses since reset. `ev_state` gives the state in which the fault arrived: run=0, wait=1, cool=2, latch=3. `ev_stage` is the backoff stage for a retry event and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 1 ms time strobe |
| fault_valid | input | 1 | One-cycle fault report |
| fault_id | input | 3 | Fault class code (R1) |
| temp | input | TEMP_W | Current temperature reading |
| cool_limit | input | TEMP_W | Temperature the reading must fall below to end cool-down |
| host_clear | input | 1 | Host release of a latched port |
| restart_ok | output | 1 | Port may be powered |
| ev_valid | output | 1 | Evidence record present |
| ev_ready | input | 1 | Consumer accepts the record |
| ev_time | output | TS_W | Tick count when the fault arrived |
| ev_fault | output | 3 | Fault code |
| ev_state | output | 2 | Port state when the fault arrived |
| ev_retries | output | RETRY_W | Retry count after the event |
| ev_stage | output | RETRY_W | Backoff stage used |
| ev_mode | output | 2 | Recovery mode applied |

## Verification
The assertions assume that `fault_valid`, `tick` and `host_clear` are one-cycle pulses sampled on the rising edge. They also assume that `temp` and `cool_limit` are stable between the edges at which they are sampled. The stimulus drives every input on the falling edge and never pulses `tick` in the same cycle as a fault, so timestamps and wait counts stay unambiguous. The bench sweeps all eight fault codes from reset and walks the full retry ladder up to escalation. It then exercises the boundaries at exactly N−1 and N ticks for the backoff wait, the hold timer and the cool-down threshold.

// File: rtl/frb_pkg.sv
package frb_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_WAIT  = 2'd1,
    ST_COOL  = 2'd2,
    ST_LATCH = 2'd3
  } pstate_e;

  typedef enum logic [1:0] {
    MD_RETRY = 2'd0,
    MD_LATCH = 2'd1,
    MD_COOL  = 2'd2
  } rmode_e;

  localparam logic [2:0] FID_SHORT = 3'd1;
  localparam logic [2:0] FID_OVERI = 3'd2;
  localparam logic [2:0] FID_OVERP = 3'd3;
  localparam logic [2:0] FID_OTEMP = 3'd4;
  localparam logic [2:0] FID_UVOLT = 3'd5;
  localparam logic [2:0] FID_DETAN = 3'd6;
endpackage

// File: rtl/frb_profile_map.sv
module frb_profile_map
  import frb_pkg::*;
(
  input  logic [2:0] fid,
  output rmode_e     mode
);
  // R1: per-class default recovery profile; unknown codes fail safe to latch
  always_comb begin
    case (fid)
      FID_SHORT: mode = MD_LATCH;
      FID_OVERI: mode = MD_RETRY;
      FID_OVERP: mode = MD_RETRY;
      FID_OTEMP: mode = MD_COOL;
      FID_UVOLT: mode = MD_RETRY;
      FID_DETAN: mode = MD_RETRY;
      default:   mode = MD_LATCH;
    endcase
  end
endmodule

// File: rtl/frb_backoff_calc.sv
module frb_backoff_calc #(
  parameter int STAGE_W    = 3,
  parameter int WAIT_W     = 3,
  parameter int BASE_TICKS = 1,
  parameter int MAX_WAIT   = 6,
  parameter bit EXP_MODE   = 1'b1
) (
  input  logic [STAGE_W-1:0] stage,
  output logic [WAIT_W-1:0]  wait_ticks
);
  logic [31:0] raw;

  generate
    if (EXP_MODE) begin : g_exp
      // R3: doubling from the base
      always_comb raw = 32'(BASE_TICKS) << stage;
    end else begin : g_step
      // R3: linear steps of the base
      always_comb raw = 32'(BASE_TICKS) * (32'(stage) + 32'd1);
    end
  endgenerate

  // saturate instead of wrapping
  always_comb begin
    if (raw > 32'(MAX_WAIT)) wait_ticks = WAIT_W'(MAX_WAIT);
    else                     wait_ticks = raw[WAIT_W-1:0];
  end
endmodule

// File: rtl/frb_evidence_reg.sv
module frb_evidence_reg #(
  parameter int TS_W    = 16,
  parameter int RETRY_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [TS_W-1:0]    in_time,
  input  logic [2:0]         in_fault,
  input  logic [1:0]         in_state,
  input  logic [RETRY_W-1:0] in_retries,
  input  logic [RETRY_W-1:0] in_stage,
  input  logic [1:0]         in_mode,
  input  logic               ready,
  output logic               valid,
  output logic [TS_W-1:0]    out_time,
  output logic [2:0]         out_fault,
  output logic [1:0]         out_state,
  output logic [RETRY_W-1:0] out_retries,
  output logic [RETRY_W-1:0] out_stage,
  output logic [1:0]         out_mode
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid       <= 1'b0;
      out_time    <= '0;
      out_fault   <= '0;
      out_state   <= '0;
      out_retries <= '0;
      out_stage   <= '0;
      out_mode    <= '0;
    end else if (load) begin
      // newest event wins over a pending record
      valid       <= 1'b1;
      out_time    <= in_time;
      out_fault   <= in_fault;
      out_state   <= in_state;
      out_retries <= in_retries;
      out_stage   <= in_stage;
      out_mode    <= in_mode;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  assert_hold_record_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !load) |=> (valid && $stable(out_time) && $stable(out_fault)
      && $stable(out_retries) && $stable(out_mode) && $stable(out_stage)));

  assert_load_sets_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> valid);
endmodule

// File: rtl/fault_recovery_ctrl.sv
module fault_recovery_ctrl
  import frb_pkg::*;
#(
  parameter int RETRY_MAX  = 4,
  parameter int BASE_TICKS = 1,
  parameter int MAX_WAIT   = 6,
  parameter bit EXP_MODE   = 1'b1,
  parameter int HOLD_TICKS = 20,
  parameter int TEMP_W     = 8,
  parameter int TS_W       = 16,
  localparam int RETRY_W   = $clog2(RETRY_MAX + 1),
  localparam int WAIT_W    = $clog2(MAX_WAIT + 1),
  localparam int HOLD_W    = $clog2(HOLD_TICKS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               fault_valid,
  input  logic [2:0]         fault_id,
  input  logic [TEMP_W-1:0]  temp,
  input  logic [TEMP_W-1:0]  cool_limit,
  input  logic               host_clear,
  output logic               restart_ok,
  output logic               ev_valid,
  input  logic               ev_ready,
  output logic [TS_W-1:0]    ev_time,
  output logic [2:0]         ev_fault,
  output logic [1:0]         ev_state,
  output logic [RETRY_W-1:0] ev_retries,
  output logic [RETRY_W-1:0] ev_stage,
  output logic [1:0]         ev_mode
);
  pstate_e            state_q, state_d;
  logic [RETRY_W-1:0] retry_q, retry_d;
  logic [WAIT_W-1:0]  wait_q, wait_d;
  logic [HOLD_W-1:0]  hold_q, hold_d;
  logic [TS_W-1:0]    ts_q;
  rmode_e             map_mode, rec_mode;
  logic [RETRY_W-1:0] rec_stage;
  logic [WAIT_W-1:0]  calc_wait;

  frb_profile_map u_map (
    .fid  (fault_id),
    .mode (map_mode)
  );

  frb_backoff_calc #(
    .STAGE_W    (RETRY_W),
    .WAIT_W     (WAIT_W),
    .BASE_TICKS (BASE_TICKS),
    .MAX_WAIT   (MAX_WAIT),
    .EXP_MODE   (EXP_MODE)
  ) u_backoff (
    .stage      (retry_q),
    .wait_ticks (calc_wait)
  );

  always_comb begin
    state_d   = state_q;
    retry_d   = retry_q;
    wait_d    = wait_q;
    hold_d    = hold_q;
    rec_mode  = MD_RETRY;
    rec_stage = '0;
    if (fault_valid) begin
      hold_d = '0;
      if (state_q == ST_LATCH) begin
        rec_mode = MD_LATCH;
      end else if (map_mode == MD_LATCH) begin
        state_d  = ST_LATCH;
        rec_mode = MD_LATCH;
      end else if (map_mode == MD_COOL) begin
        state_d  = ST_COOL;
        rec_mode = MD_COOL;
      end else if (state_q == ST_COOL) begin
        rec_mode = MD_COOL;
      end else if (retry_q == RETRY_W'(RETRY_MAX)) begin
        state_d  = ST_LATCH;           // escalation after cap
        rec_mode = MD_LATCH;
      end else begin
        retry_d   = retry_q + 1'b1;
        rec_stage = retry_q;
        wait_d    = calc_wait;
        state_d   = ST_WAIT;
      end
    end else begin
      case (state_q)
        ST_RUN: if (tick) begin
          if (hold_q == HOLD_W'(HOLD_TICKS - 1)) begin
            retry_d = '0;
            hold_d  = '0;
          end else begin
            hold_d = hold_q + 1'b1;
          end
        end
        ST_WAIT: if (tick) begin
          if (wait_q <= WAIT_W'(1)) begin
            state_d = ST_RUN;
            hold_d  = '0;
          end else begin
            wait_d = wait_q - 1'b1;
          end
        end
        ST_COOL: if (temp < cool_limit) begin
          state_d = ST_RUN;
          hold_d  = '0;
        end
        ST_LATCH: if (host_clear) begin
          state_d = ST_RUN;
          retry_d = '0;
          hold_d  = '0;
        end
        default: state_d = ST_LATCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      retry_q <= '0;
      wait_q  <= '0;
      hold_q  <= '0;
      ts_q    <= '0;
    end else begin
      state_q <= state_d;
      retry_q <= retry_d;
      wait_q  <= wait_d;
      hold_q  <= hold_d;
      if (tick) ts_q <= ts_q + 1'b1;
    end
  end

  assign restart_ok = (state_q == ST_RUN);

  frb_evidence_reg #(
    .TS_W    (TS_W),
    .RETRY_W (RETRY_W)
  ) u_evid (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (fault_valid),
    .in_time     (ts_q),
    .in_fault    (fault_id),
    .in_state    (state_q),
    .in_retries  (retry_d),
    .in_stage    (rec_stage),
    .in_mode     (rec_mode),
    .ready       (ev_ready),
    .valid       (ev_valid),
    .out_time    (ev_time),
    .out_fault   (ev_fault),
    .out_state   (ev_state),
    .out_retries (ev_retries),
    .out_stage   (ev_stage),
    .out_mode    (ev_mode)
  );

  assert_drop_on_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> !restart_ok);

  assert_retry_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    retry_q <= RETRY_W'(RETRY_MAX));

  assert_wait_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (wait_q >= WAIT_W'(1) && wait_q <= WAIT_W'(MAX_WAIT)));

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LATCH && !host_clear) |=> (state_q == ST_LATCH));

  assert_cool_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COOL && temp >= cool_limit) |=> !restart_ok);

  assert_clear_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !tick && !fault_valid) |=> (state_q == ST_WAIT));
endmodule

// File: tb/fault_recovery_ctrl_bench.sv
module fault_recovery_ctrl_bench;
  localparam int RMAX = 4;
  localparam int MAXW = 6;
  localparam int HOLD = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       fault_valid = 1'b0;
  logic [2:0] fault_id = 3'd0;
  logic [7:0] temp = 8'd50;
  logic [7:0] cool_limit = 8'd40;
  logic       host_clear = 1'b0;
  logic       restart_ok;
  logic       ev_valid;
  logic       ev_ready = 1'b1;
  logic [15:0] ev_time;
  logic [2:0] ev_fault;
  logic [1:0] ev_state;
  logic [2:0] ev_retries;
  logic [2:0] ev_stage;
  logic [1:0] ev_mode;

  int checks = 0;
  int fails = 0;
  int tick_count = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fault_recovery_ctrl #(
    .RETRY_MAX(RMAX), .BASE_TICKS(1), .MAX_WAIT(MAXW), .EXP_MODE(1'b1),
    .HOLD_TICKS(HOLD), .TEMP_W(8), .TS_W(16)
  ) u_fault_recovery_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fault_valid(fault_valid),
    .fault_id(fault_id), .temp(temp), .cool_limit(cool_limit),
    .host_clear(host_clear), .restart_ok(restart_ok), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_time(ev_time), .ev_fault(ev_fault),
    .ev_state(ev_state), .ev_retries(ev_retries), .ev_stage(ev_stage),
    .ev_mode(ev_mode)
  );

  function automatic int exp_mode(int id);
    case (id)
      2, 3, 5, 6: return 0;
      4:          return 2;
      default:    return 1;
    endcase
  endfunction

  function automatic int exp_wait(int stage);
    int w = 1 << stage;
    return (w > MAXW) ? MAXW : w;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    temp = 8'd50;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tick_count = 0;
  endtask

  task automatic fault(int id);
    @(negedge clk);
    fault_valid = 1'b1;
    fault_id = 3'(id);
    @(negedge clk);
    fault_valid = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      tick_count++;
    end
  endtask

  task automatic clear_pulse();
    @(negedge clk);
    host_clear = 1'b1;
    @(negedge clk);
    host_clear = 1'b0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R2 reset restart_ok", int'(restart_ok), 1);
    chk("R9 reset ev_valid", int'(ev_valid), 0);

    // R1 / R11 sweep of every fault code
    for (int id = 0; id < 8; id++) begin
      do_reset();
      ticks(id);
      fault(id);
      chk("R1 mode", int'(ev_mode), exp_mode(id));
      chk("R11 fault code", int'(ev_fault), id);
      chk("R11 timestamp", int'(ev_time), tick_count);
      chk("R11 state run", int'(ev_state), 0);
      chk("R2 drop", int'(restart_ok), 0);
      if (exp_mode(id) == 0) begin
        ticks(1);
        chk("R3 stage0 recover", int'(restart_ok), 1);
      end else if (exp_mode(id) == 1) begin
        ticks(3);
        chk("R5 latch held", int'(restart_ok), 0);
        clear_pulse();
        chk("R5 clear", int'(restart_ok), 1);
      end else begin
        ticks(5);
        temp = 8'd40;
        @(negedge clk);
        @(negedge clk);
        chk("R6 equal temp held", int'(restart_ok), 0);
        temp = 8'd39;
        @(negedge clk);
        chk("R6 below limit", int'(restart_ok), 1);
      end
    end

    // R3 / R4 retry ladder with saturation and escalation
    do_reset();
    for (int k = 0; k < RMAX; k++) begin
      fault(2);
      chk("R3 retries", int'(ev_retries), k + 1);
      chk("R3 stage", int'(ev_stage), k);
      chk("R3 mode", int'(ev_mode), 0);
      if (exp_wait(k) > 1) begin
        ticks(exp_wait(k) - 1);
        chk("R3 still waiting", int'(restart_ok), 0);
      end
      ticks(1);
      chk("R3 wait done", int'(restart_ok), 1);
    end
    fault(2);
    chk("R4 escalate mode", int'(ev_mode), 1);
    chk("R4 count held", int'(ev_retries), RMAX);
    ticks(10);
    chk("R5 ticks do not release", int'(restart_ok), 0);
    fault(3);
    chk("R5 fault in latch", int'(ev_mode), 1);
    chk("R5 latch state", int'(ev_state), 3);
    clear_pulse();
    chk("R5 clear release", int'(restart_ok), 1);
    fault(2);
    chk("R5 count reset", int'(ev_retries), 1);

    // R7 fault during backoff
    do_reset();
    fault(2);
    ticks(1);
    fault(2);
    ticks(1);
    fault(5);
    chk("R7 state wait", int'(ev_state), 1);
    chk("R7 stage", int'(ev_stage), 2);
    ticks(exp_wait(2) - 1);
    chk("R7 restarted wait", int'(restart_ok), 0);
    ticks(1);
    chk("R7 wait end", int'(restart_ok), 1);

    // R8 hold timer
    do_reset();
    fault(2);
    ticks(1);
    ticks(HOLD - 1);
    fault(2);
    chk("R8 short hold keeps count", int'(ev_retries), 2);
    ticks(exp_wait(1));
    ticks(HOLD);
    fault(2);
    chk("R8 full hold clears", int'(ev_retries), 1);

    // R10 clear ignored while waiting
    do_reset();
    fault(6);
    ticks(1);
    fault(6);
    clear_pulse();
    chk("R10 clear in wait", int'(restart_ok), 0);
    ticks(exp_wait(1));
    chk("R10 wait completes", int'(restart_ok), 1);

    // R6 retry fault during cool-down
    do_reset();
    fault(4);
    fault(2);
    chk("R6 cool mode kept", int'(ev_mode), 2);
    chk("R6 cool state", int'(ev_state), 2);
    chk("R6 no retry count", int'(ev_retries), 0);
    ticks(8);
    chk("R6 ticks ignored", int'(restart_ok), 0);
    temp = 8'd10;
    @(negedge clk);
    chk("R6 cooled", int'(restart_ok), 1);

    // R9 back-pressure
    do_reset();
    ev_ready = 1'b0;
    ticks(2);
    fault(3);
    repeat (4) @(negedge clk);
    chk("R9 held valid", int'(ev_valid), 1);
    chk("R9 held fault", int'(ev_fault), 3);
    chk("R9 held time", int'(ev_time), 2);
    fault(1);
    chk("R9 overwrite", int'(ev_fault), 1);
    chk("R9 overwrite mode", int'(ev_mode), 1);
    ev_ready = 1'b1;
    @(negedge clk);
    chk("R9 drained", int'(ev_valid), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule